// File: doc/BRIEF.md
# VGA Raster Timing Generator

This block produces the raster timing for a 640x480 display from a pixel-rate clock enable. The clock enable is asserted at 25.175 MHz. A horizontal position counter and a vertical line counter both advance on that enable. Each counter has a small phase state machine with four states: active, front porch, sync and back porch. The sync pulses, the blanking flags and the counter values are all derived from those phases and counts, and all are registered. Each output therefore changes on exactly the count where its boundary lies. A count decoded in one cycle never shows up late in the next.

The block has three blanking outputs.
- The display blank gates pixel data.
- The host blank covers the same interval as the display blank, except that it ends a set number of pixels before the next visible pixel. A memory master that finds it asserted always has enough time to finish a write before the video fetch takes the memory back.
- The frame blank covers only the vertical blanking lines. It is meant to drive a once-per-frame interrupt.

The horizontal phase machine moves through its states in this order:
- ACTIVE to FRONT after the last visible pixel (count 639).
- FRONT to SYNC after count 655.
- SYNC to BACK after count 751.
- BACK to ACTIVE on the line wrap after count 799.

The vertical machine follows the same four transitions at lines 479, 489, 491 and 524. It advances one step each time the horizontal counter wraps.

Top module: `vga_timing`

## Requirements
- R1: `h_count` steps by one on each cycle with `pix_en` high, runs from 0 to 799, and returns to 0 after 799.
- R2: `v_count` steps by one when `h_count` wraps from 799 to 0. It runs from 0 to 524 and returns to 0 after 524.
- R3: `disp_blank` is 1 exactly when `h_count` >= 640 or `v_count` >= 480, in the same cycle as those counts.
- R4: `hsync_n` is 0 exactly when `h_count` is in 656..751, and is 1 otherwise.
- R5: `vsync_n` is 0 exactly when `v_count` is 490 or 491, and is 1 otherwise.
- R6: `host_blank` equals `disp_blank`, with one exception. It is 0 when `h_count` >= 800 - `HOST_MARGIN` (default 8, so 792..799) and the next line is visible, which means `v_count` is 524 or `v_count` < 479.
- R7: `frame_blank` is 1 exactly when `v_count` >= 480.
- R8: In a cycle with `pix_en` low, the counts and every output keep their values.
- R9: A synchronous active-low reset sets both counts to 0, both syncs to 1 and all three blanks to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| pix_en | input | 1 | Pixel-rate enable; each high cycle is one pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| disp_blank | output | 1 | High outside the visible area |
| host_blank | output | 1 | Blank window that is safe for host memory access |
| frame_blank | output | 1 | High during the vertical blanking lines only |
| h_count | output | $clog2(H_TOTAL) | Current pixel position in the line |
| v_count | output | $clog2(V_TOTAL) | Current line in the frame |

## Verification
The bench builds two instances. The first has a shrunken raster: 16 visible pixels, porches of 3 and 5, a 4-pixel sync, 6 visible lines, a 3-pixel host margin and 13 lines per frame. With this raster, every vertical transition, both frame wraps and the host window on the last line before a frame all occur many times within the cycle budget. The second instance uses the default 640x480 parameters and runs for a few lines. This confirms the real horizontal boundaries at 639/640, 655/656, 751/752 and 799/0, and the 8-pixel host window at 792. Random gaps in `pix_en` test the hold behaviour at every phase, and a reset in the middle of the run tests recovery from an arbitrary position.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    // Phase of one raster axis; the order is the order of traversal.
    typedef enum logic [1:0] {
        PH_ACTIVE,
        PH_FRONT,
        PH_SYNC,
        PH_BACK
    } phase_t;

endpackage

// File: rtl/vga_axis.sv
// One raster axis: a position counter plus a four-phase state machine.
// Each transition is decoded one count early, so the phase register and the
// count register change on the same edge.
module vga_axis
    import vga_timing_pkg::*;
#(
    parameter int ACTIVE = 640,
    parameter int FRONT  = 16,
    parameter int SYNC   = 96,
    parameter int BACK   = 48,
    localparam int TOTAL = ACTIVE + FRONT + SYNC + BACK,
    localparam int W     = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt,
    output logic [W-1:0] cnt_nxt,
    output phase_t       phase_nxt,
    output logic         wrap
);

    localparam logic [W-1:0] LAST_ACTIVE = W'(ACTIVE - 1);
    localparam logic [W-1:0] LAST_FRONT  = W'(ACTIVE + FRONT - 1);
    localparam logic [W-1:0] LAST_SYNC   = W'(ACTIVE + FRONT + SYNC - 1);
    localparam logic [W-1:0] LAST_COUNT  = W'(TOTAL - 1);

    phase_t phase_q;

    always_comb begin
        wrap = step && (cnt == LAST_COUNT);
    end

    always_comb begin
        cnt_nxt = cnt;
        if (step) begin
            cnt_nxt = (cnt == LAST_COUNT) ? '0 : cnt + 1'b1;
        end
    end

    // Transition logic: ACTIVE->FRONT, FRONT->SYNC, SYNC->BACK, BACK->ACTIVE.
    always_comb begin
        phase_nxt = phase_q;
        unique case (phase_q)
            PH_ACTIVE: if (step && cnt == LAST_ACTIVE) phase_nxt = PH_FRONT;
            PH_FRONT:  if (step && cnt == LAST_FRONT)  phase_nxt = PH_SYNC;
            PH_SYNC:   if (step && cnt == LAST_SYNC)   phase_nxt = PH_BACK;
            PH_BACK:   if (step && cnt == LAST_COUNT)  phase_nxt = PH_ACTIVE;
            default:   phase_nxt = PH_ACTIVE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_ACTIVE;
            cnt     <= '0;
        end else begin
            phase_q <= phase_nxt;
            cnt     <= cnt_nxt;
        end
    end

endmodule

// File: rtl/vga_outputs.sv
// Output registers. They are fed from the next-state values of both axes,
// so each flag lines up with the count that is registered on the same edge.
module vga_outputs
    import vga_timing_pkg::*;
#(
    parameter int H_TOTAL = 800,
    parameter int V_ACTIVE = 480,
    parameter int V_TOTAL = 525,
    parameter int MARGIN  = 8,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  phase_t        h_phase_nxt,
    input  phase_t        v_phase_nxt,
    input  logic [HW-1:0] h_cnt_nxt,
    input  logic [VW-1:0] v_cnt_nxt,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          disp_blank,
    output logic          host_blank,
    output logic          frame_blank
);

    logic blank_d;
    logic next_line_visible;
    logic closing_window;

    always_comb begin
        blank_d           = (h_phase_nxt != PH_ACTIVE) || (v_phase_nxt != PH_ACTIVE);
        next_line_visible = (int'(v_cnt_nxt) == V_TOTAL - 1) ||
                            (int'(v_cnt_nxt) <  V_ACTIVE - 1);
        closing_window    = (int'(h_cnt_nxt) >= H_TOTAL - MARGIN) && next_line_visible;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hsync_n     <= 1'b1;
            vsync_n     <= 1'b1;
            disp_blank  <= 1'b0;
            host_blank  <= 1'b0;
            frame_blank <= 1'b0;
        end else begin
            hsync_n     <= (h_phase_nxt != PH_SYNC);
            vsync_n     <= (v_phase_nxt != PH_SYNC);
            disp_blank  <= blank_d;
            host_blank  <= blank_d && !closing_window;
            frame_blank <= (v_phase_nxt != PH_ACTIVE);
        end
    end

endmodule

// File: rtl/vga_timing.sv
module vga_timing
    import vga_timing_pkg::*;
#(
    parameter int H_ACTIVE    = 640,
    parameter int H_FRONT     = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BACK      = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FRONT     = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BACK      = 33,
    parameter int HOST_MARGIN = 8,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pix_en,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          disp_blank,
    output logic          host_blank,
    output logic          frame_blank,
    output logic [HW-1:0] h_count,
    output logic [VW-1:0] v_count
);

    phase_t        h_phase_nxt;
    phase_t        v_phase_nxt;
    logic [HW-1:0] h_cnt_nxt;
    logic [VW-1:0] v_cnt_nxt;
    logic          h_wrap;
    logic          v_wrap;

    vga_axis #(
        .ACTIVE(H_ACTIVE), .FRONT(H_FRONT), .SYNC(H_SYNC), .BACK(H_BACK)
    ) u_h_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (pix_en),
        .cnt       (h_count),
        .cnt_nxt   (h_cnt_nxt),
        .phase_nxt (h_phase_nxt),
        .wrap      (h_wrap)
    );

    vga_axis #(
        .ACTIVE(V_ACTIVE), .FRONT(V_FRONT), .SYNC(V_SYNC), .BACK(V_BACK)
    ) u_v_axis (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (h_wrap),
        .cnt       (v_count),
        .cnt_nxt   (v_cnt_nxt),
        .phase_nxt (v_phase_nxt),
        .wrap      (v_wrap)
    );

    vga_outputs #(
        .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE), .V_TOTAL(V_TOTAL), .MARGIN(HOST_MARGIN)
    ) u_outputs (
        .clk         (clk),
        .rst_n       (rst_n),
        .h_phase_nxt (h_phase_nxt),
        .v_phase_nxt (v_phase_nxt),
        .h_cnt_nxt   (h_cnt_nxt),
        .v_cnt_nxt   (v_cnt_nxt),
        .hsync_n     (hsync_n),
        .vsync_n     (vsync_n),
        .disp_blank  (disp_blank),
        .host_blank  (host_blank),
        .frame_blank (frame_blank)
    );

    logic unused_v_wrap;
    assign unused_v_wrap = v_wrap;

endmodule

// File: rtl/vga_timing_chk.sv
module vga_timing_chk #(
    parameter int H_ACTIVE    = 640,
    parameter int H_FRONT     = 16,
    parameter int H_SYNC      = 96,
    parameter int H_BACK      = 48,
    parameter int V_ACTIVE    = 480,
    parameter int V_FRONT     = 10,
    parameter int V_SYNC      = 2,
    parameter int V_BACK      = 33,
    parameter int HOST_MARGIN = 8,
    localparam int H_TOTAL = H_ACTIVE + H_FRONT + H_SYNC + H_BACK,
    localparam int V_TOTAL = V_ACTIVE + V_FRONT + V_SYNC + V_BACK,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          pix_en,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          disp_blank,
    input logic          host_blank,
    input logic          frame_blank,
    input logic [HW-1:0] h_count,
    input logic [VW-1:0] v_count
);

    AST_H_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        int'(h_count) < H_TOTAL); // R1

    AST_H_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && int'(h_count) == H_TOTAL - 1) |=> (h_count == '0)); // R1

    AST_V_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_en && int'(h_count) == H_TOTAL - 1 && int'(v_count) == V_TOTAL - 1)
            |=> (v_count == '0)); // R2

    AST_DISP_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        disp_blank == (int'(h_count) >= H_ACTIVE || int'(v_count) >= V_ACTIVE)); // R3

    AST_HSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !hsync_n == (int'(h_count) >= H_ACTIVE + H_FRONT &&
                     int'(h_count) <  H_ACTIVE + H_FRONT + H_SYNC)); // R4

    AST_VSYNC_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_n == (int'(v_count) >= V_ACTIVE + V_FRONT &&
                     int'(v_count) <  V_ACTIVE + V_FRONT + V_SYNC)); // R5

    AST_HOST_INSIDE_DISP: assert property (@(posedge clk) disable iff (!rst_n)
        host_blank |-> disp_blank); // R6

    AST_FRAME_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        frame_blank == (int'(v_count) >= V_ACTIVE)); // R7

    AST_HOLD_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_en |=> ($stable(h_count) && $stable(v_count) && $stable(host_blank))); // R8

endmodule

bind vga_timing vga_timing_chk #(
    .H_ACTIVE(H_ACTIVE), .H_FRONT(H_FRONT), .H_SYNC(H_SYNC), .H_BACK(H_BACK),
    .V_ACTIVE(V_ACTIVE), .V_FRONT(V_FRONT), .V_SYNC(V_SYNC), .V_BACK(V_BACK),
    .HOST_MARGIN(HOST_MARGIN)
) u_vga_timing_chk (
    .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
    .hsync_n(hsync_n), .vsync_n(vsync_n),
    .disp_blank(disp_blank), .host_blank(host_blank), .frame_blank(frame_blank),
    .h_count(h_count), .v_count(v_count)
);

// File: tb/test_vga_timing.sv
module test_vga_timing;

    localparam int CLK_PERIOD = 10;

    // Shrunken raster.
    localparam int SHA = 16, SHF = 3, SHS = 4, SHB = 5;
    localparam int SVA = 6,  SVF = 2, SVS = 2, SVB = 3;
    localparam int SM  = 3;
    localparam int SHT = SHA + SHF + SHS + SHB;
    localparam int SVT = SVA + SVF + SVS + SVB;
    // Default raster.
    localparam int DHA = 640, DHF = 16, DHS = 96, DHB = 48;
    localparam int DVA = 480, DVF = 10, DVS = 2,  DVB = 33;
    localparam int DM  = 8;
    localparam int DHT = DHA + DHF + DHS + DHB;
    localparam int DVT = DVA + DVF + DVS + DVB;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pix_en = 1'b0;

    logic s_hs, s_vs, s_db, s_hb, s_fb;
    logic [$clog2(SHT)-1:0] s_h;
    logic [$clog2(SVT)-1:0] s_v;
    logic d_hs, d_vs, d_db, d_hb, d_fb;
    logic [$clog2(DHT)-1:0] d_h;
    logic [$clog2(DVT)-1:0] d_v;

    int checks = 0;
    int fails  = 0;
    int sh = 0, sv = 0, dh = 0, dv = 0;
    bit last_en = 1'b0;
    bit last_rst = 1'b1;
    int prev_sh = 0, prev_sv = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    vga_timing #(
        .H_ACTIVE(SHA), .H_FRONT(SHF), .H_SYNC(SHS), .H_BACK(SHB),
        .V_ACTIVE(SVA), .V_FRONT(SVF), .V_SYNC(SVS), .V_BACK(SVB),
        .HOST_MARGIN(SM)
    ) i_vga_timing (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hsync_n(s_hs), .vsync_n(s_vs), .disp_blank(s_db), .host_blank(s_hb),
        .frame_blank(s_fb), .h_count(s_h), .v_count(s_v)
    );

    vga_timing i_vga_timing_def (
        .clk(clk), .rst_n(rst_n), .pix_en(pix_en),
        .hsync_n(d_hs), .vsync_n(d_vs), .disp_blank(d_db), .host_blank(d_hb),
        .frame_blank(d_fb), .h_count(d_h), .v_count(d_v)
    );

    function automatic int f_disp(int h, int v, int ha, int va);
        return (h >= ha || v >= va) ? 1 : 0;
    endfunction

    function automatic int f_sync_n(int c, int act, int fr, int sy);
        return (c >= act + fr && c < act + fr + sy) ? 0 : 1;
    endfunction

    function automatic int f_host(int h, int v, int ha, int ht, int va, int vt, int m);
        bit nxt_vis;
        nxt_vis = (v == vt - 1) || (v < va - 1);
        return (f_disp(h, v, ha, va) == 1 && !(h >= ht - m && nxt_vis)) ? 1 : 0;
    endfunction

    task automatic cmp(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic check_all();
        // Shrunken instance
        cmp("R1 small h_count", int'(s_h), sh);
        cmp("R2 small v_count", int'(s_v), sv);
        cmp("R3 small disp_blank", int'(s_db), f_disp(sh, sv, SHA, SVA));
        cmp("R4 small hsync_n", int'(s_hs), f_sync_n(sh, SHA, SHF, SHS));
        cmp("R5 small vsync_n", int'(s_vs), f_sync_n(sv, SVA, SVF, SVS));
        cmp("R6 small host_blank", int'(s_hb), f_host(sh, sv, SHA, SHT, SVA, SVT, SM));
        cmp("R7 small frame_blank", int'(s_fb), (sv >= SVA) ? 1 : 0);
        if (!last_en && !last_rst) begin
            cmp("R8 hold h_count", int'(s_h), prev_sh);
            cmp("R8 hold v_count", int'(s_v), prev_sv);
        end
        if (last_rst) begin
            cmp("R9 reset h_count", int'(s_h), 0);
            cmp("R9 reset v_count", int'(s_v), 0);
            cmp("R9 reset hsync_n", int'(s_hs), 1);
            cmp("R9 reset vsync_n", int'(s_vs), 1);
            cmp("R9 reset host_blank", int'(s_hb), 0);
        end
        // Default instance
        cmp("R1 default h_count", int'(d_h), dh);
        cmp("R2 default v_count", int'(d_v), dv);
        cmp("R3 default disp_blank", int'(d_db), f_disp(dh, dv, DHA, DVA));
        cmp("R4 default hsync_n", int'(d_hs), f_sync_n(dh, DHA, DHF, DHS));
        cmp("R5 default vsync_n", int'(d_vs), f_sync_n(dv, DVA, DVF, DVS));
        cmp("R6 default host_blank", int'(d_hb), f_host(dh, dv, DHA, DHT, DVA, DVT, DM));
        cmp("R7 default frame_blank", int'(d_fb), (dv >= DVA) ? 1 : 0);
        prev_sh = int'(s_h);
        prev_sv = int'(s_v);
    endtask

    // Check at the falling edge, then set inputs for the next rising edge
    // and advance the bench's own model to match.
    task automatic step(bit en, bit rst);
        @(negedge clk);
        check_all();
        pix_en   = en;
        rst_n    = !rst;
        last_en  = en;
        last_rst = rst;
        if (rst) begin
            sh = 0; sv = 0; dh = 0; dv = 0;
        end else if (en) begin
            if (sh == SHT - 1) begin
                sh = 0;
                sv = (sv == SVT - 1) ? 0 : sv + 1;
            end else begin
                sh++;
            end
            if (dh == DHT - 1) begin
                dh = 0;
                dv = (dv == DVT - 1) ? 0 : dv + 1;
            end else begin
                dh++;
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        int unsigned seed_val;
        seed_val = $urandom(32'h00C0FFEE);
        repeat (3) @(posedge clk);
        // R9: the first check sees the reset state; release it here.
        step(1'b1, 1'b0);
        // Directed: one full small frame with the enable held high (R1, R2, R6 wrap)
        for (int i = 0; i < SHT * SVT + 2; i++) step(1'b1, 1'b0);
        // Directed: a long enable gap (R8)
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0);
        // Random enable pattern, about three quarters high
        for (int i = 0; i < 2800; i++) step(($urandom % 4) != 0, 1'b0);
        // Reset in mid-frame (R9), then more random traffic
        step(1'b1, 1'b1);
        step(1'b0, 1'b1);
        for (int i = 0; i < 600; i++) step(($urandom % 4) != 0, 1'b0);
        step(1'b0, 1'b0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule